// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector with Integer Divider

This cell picks one of up to seventeen incoming clocks, optionally divides it by an integer, and gates the result onto a single clock output. Software controls it through one 32-bit control word. It writes the word with a one-cycle write strobe in the register clock domain and can always read it back. Source input bit `i` carries source ID `i`. Each instance has a parameter mask that says which IDs it may select. The reserved IDs 5, 10 and 11 are simply left out of every mask.

Parameters set the variant. A divider instance carries a divide field of configurable width. A selector instance has no divider and passes the chosen clock straight through. A safe selector is pinned to its reset source, ignores writes to the select field and can never be powered down. A change of source goes through a two-flop handshake on the falling edges of the old and new clocks. The output therefore never produces a runt pulse while the source changes.

Top module: `clk_sel_div`

## Requirements
- R1: After reset the select field holds the reset source (ID 1 by default), the divide field is 0 and the power-down bit is 0, so a default instance reads 0x0100_0000.
- R2: The select field is bits 28:24, the divide field starts at bit 2 and is DIV_W bits wide, and the power-down bit is bit 0. Bit 1, bits 31:29 and the bits between the divide field and bit 24 read as 0 whatever was written.
- R3: A write whose select value is not allowed by the instance's mask leaves the select field unchanged, while the divide and power-down fields of that write still take effect. Values outside 0..16 and the reserved IDs count as not allowed. The default mask allows IDs 0-4, 6, 8, 9 and 12.
- R4: With divide field value D, the output period is (D+1) times the period of the selected source.
- R5: When D+1 is even, or D is 0, the output is high for exactly half of its period.
- R6: Writing 1 to bit 0 holds the output low, and writing 0 restarts it.
- R7: While the source changes, no high or low output pulse is shorter than the shorter half period of the two clocks involved, and at most one source is enabled at any time.
- R8: In the safe variant the select field stays at its reset source and bit 0 reads 0. The output keeps running through any write.
- R9: In the variant without a divider the divide field reads 0 and the output period equals the source period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| src_clk | input | NSRC | Source clocks, bit i is source ID i |
| clk_out | output | 1 | Selected, divided and gated clock |

## Verification
A single control write can change the source and set the power-down bit at the same time. The source handshake and the output gate then act together, on two different clocks. The bench makes such a combined write and then checks two things: the output stays low with the readback showing the new source and power-down set, and after power-down is cleared the output runs at the new source's divided period. A second overlap is the switch itself. The old clock is released while the new one is being claimed, and a pulse-width monitor checks that the output never shows a pulse shorter than the faster clock's half period.

// File: rtl/clk_sel_div.sv
`timescale 1ns/1ps
module clk_sel_div #(
  parameter int              NSRC       = 17,
  parameter int              DIV_W      = 4,
  parameter int              HAS_DIV    = 1,
  parameter logic [NSRC-1:0] LEGAL_MASK = 17'h0135F,
  parameter int              SAFE       = 0,
  parameter int              RST_SEL    = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  input  logic [NSRC-1:0] src_clk,
  output logic            clk_out
);
  localparam int SEL_LSB = 24;
  localparam int DIV_LSB = 2;

  logic [4:0]       sel_q;
  logic [DIV_W-1:0] div_q;
  logic             pd_q;
  logic [4:0]       wsel;
  logic [NSRC-1:0]  en;
  logic             mclk, dclk;
  logic             g1, g2;

  assign wsel = wr_data[SEL_LSB +: 5];

  function automatic logic sel_ok(input logic [4:0] s);
    logic [NSRC-1:0] sh;
    sh = LEGAL_MASK >> s;
    return sh[0];
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= RST_SEL[4:0];
      div_q <= '0;
      pd_q  <= 1'b0;
    end else if (wr_en) begin
      if (SAFE == 0 && sel_ok(wsel)) sel_q <= wsel;
      if (HAS_DIV != 0) div_q <= wr_data[DIV_LSB +: DIV_W];
      pd_q <= (SAFE == 0) && wr_data[0];
    end

  always_comb begin
    rd_data = '0;
    rd_data[SEL_LSB +: 5] = sel_q;
    rd_data[DIV_LSB +: DIV_W] = div_q;
    rd_data[0] = pd_q;
  end

  wire unused_wr = ^{wr_data[31:29], wr_data[23:DIV_LSB+DIV_W], wr_data[1]};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic s1, s2, req, busy;
    assign req  = LEGAL_MASK[i] && (sel_q == 5'(i));
    assign busy = |(en & ~(NSRC'(1) << i));
    always_ff @(negedge src_clk[i] or negedge rst_n)
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= req & ~busy;
        s2 <= s1;
      end
    assign en[i] = s2;
  end

  assign mclk = |(src_clk & en);

  if (HAS_DIV != 0) begin : g_div
    logic [DIV_W-1:0] cnt, cnt_nx;
    logic [DIV_W:0]   half;
    logic             dv;
    assign cnt_nx = (cnt >= div_q) ? '0 : cnt + 1'b1;
    assign half   = ({1'b0, div_q} + 1'b1) >> 1;
    always_ff @(posedge mclk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        dv  <= 1'b0;
      end else begin
        cnt <= cnt_nx;
        dv  <= ({1'b0, cnt_nx} < half);
      end
    assign dclk = (div_q == '0) ? mclk : dv;
  end else begin : g_nodiv
    assign dclk = mclk;
  end

  always_ff @(negedge dclk or negedge rst_n)
    if (!rst_n) begin
      g1 <= 1'b0;
      g2 <= 1'b0;
    end else begin
      g1 <= ~pd_q;
      g2 <= g1;
    end

  assign clk_out = dclk & g2;
endmodule

// File: rtl/clk_sel_div_chk.sv
`timescale 1ns/1ps
module clk_sel_div_chk #(
  parameter int              NSRC       = 17,
  parameter int              DIV_W      = 4,
  parameter int              HAS_DIV    = 1,
  parameter logic [NSRC-1:0] LEGAL_MASK = 17'h0135F,
  parameter int              SAFE       = 0,
  parameter int              RST_SEL    = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [31:0]     wr_data,
  input logic [31:0]     rd_data,
  input logic [NSRC-1:0] en
);
  function automatic logic allowed(input logic [4:0] s);
    logic [NSRC-1:0] sh;
    sh = LEGAL_MASK >> s;
    return sh[0];
  endfunction

  a_r3_illegal_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !allowed(wr_data[28:24]) |=> $stable(rd_data[28:24]));

  a_r3_sel_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    allowed(rd_data[28:24]));

  a_r2_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:29] == 3'b000 && rd_data[1] == 1'b0);

  a_r2_div_written: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_DIV != 0) && wr_en |=> rd_data[2 +: DIV_W] == $past(wr_data[2 +: DIV_W]));

  a_r6_pd_written: assert property (@(posedge clk) disable iff (!rst_n)
    (SAFE == 0) && wr_en |=> rd_data[0] == $past(wr_data[0]));

  a_r7_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en));

  a_r8_safe_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (SAFE != 0) && wr_en |=> $stable(rd_data[28:24]) && !rd_data[0]);
endmodule

bind clk_sel_div clk_sel_div_chk #(
  .NSRC(NSRC), .DIV_W(DIV_W), .HAS_DIV(HAS_DIV),
  .LEGAL_MASK(LEGAL_MASK), .SAFE(SAFE), .RST_SEL(RST_SEL)
) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .en(en)
);

// File: tb/clk_sel_div_test.sv
`timescale 1ns/1ps
module clk_sel_div_test;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  wire  [31:0] rd, rd_s;
  wire  [16:0] src;
  wire         co, co_s;
  int          checks = 0, fails = 0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < 17; g++) begin : g_clk
    logic c = 1'b0;
    initial forever #(3 + g) c = ~c;
    assign src[g] = c;
  end

  clk_sel_div #(.NSRC(17), .DIV_W(8), .HAS_DIV(1), .LEGAL_MASK(17'h0135F),
                .SAFE(0), .RST_SEL(1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd), .src_clk(src), .clk_out(co));

  clk_sel_div #(.NSRC(17), .DIV_W(4), .HAS_DIV(0), .LEGAL_MASK(17'h00002),
                .SAFE(1), .RST_SEL(1)) uut_safe (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_s), .src_clk(src), .clk_out(co_s));

  // sel[23:19] div[18:11] period[10:0]
  localparam logic [23:0] VEC [6] = '{
    {5'd1,  8'd0, 11'd8},  {5'd1, 8'd1, 11'd16}, {5'd4, 8'd3, 11'd56},
    {5'd9,  8'd2, 11'd72}, {5'd12, 8'd0, 11'd30}, {5'd0, 8'd7, 11'd48}};

  real t_r = -1.0, t_f = -1.0, min_hi = 1.0e9, min_lo = 1.0e9;
  bit  arm = 1'b0;

  always @(posedge co) begin
    if (arm && t_f >= 0.0 && ($realtime - t_f) < min_lo) min_lo = $realtime - t_f;
    t_r = $realtime;
  end
  always @(negedge co) begin
    if (arm && t_r >= 0.0 && ($realtime - t_r) < min_hi) min_hi = $realtime - t_r;
    t_f = $realtime;
  end

  function automatic logic [31:0] wd(input int s, input int d, input int p);
    return (32'(s) << 24) | (32'(d) << 2) | 32'(p);
  endfunction

  task automatic chk(input string r, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", r, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic measure(input bit which, output int per, output int hi);
    logic prv, cur;
    real  tr1 = -1.0, tf = -1.0;
    int   nr = 0;
    per = 0;
    hi  = 0;
    #0.5;
    prv = which ? co_s : co;
    for (int k = 0; k < 1200 && nr < 2; k++) begin
      #1;
      cur = which ? co_s : co;
      if (!prv && cur) begin
        if (nr == 0) tr1 = $realtime;
        else per = $rtoi($realtime - tr1);
        nr++;
      end
      if (prv && !cur && nr == 1 && tf < 0.0) tf = $realtime;
      prv = cur;
    end
    if (nr >= 1 && tf >= 0.0) hi = $rtoi(tf - tr1);
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int per, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word", rd, 32'h0100_0000);
    chk("R1 safe reset word", rd_s, 32'h0100_0000);

    for (int v = 0; v < 6; v++) begin
      int s, d, p;
      s = int'(VEC[v][23:19]);
      d = int'(VEC[v][18:11]);
      p = int'(VEC[v][10:0]);
      wr(wd(s, d, 0));
      #600;
      chk("R2 readback", rd, wd(s, d, 0));
      measure(1'b0, per, hi);
      chk("R4 period", per, p);
      if (d == 0 || ((d + 1) % 2) == 0) chk("R5 high time", hi, p / 2);
    end

    wr(wd(7, 1, 0));  chk("R3 unlisted ID 7", rd, wd(0, 1, 0));
    wr(wd(5, 1, 0));  chk("R3 reserved ID 5", rd, wd(0, 1, 0));
    wr(wd(20, 1, 0)); chk("R3 ID 20 out of range", rd, wd(0, 1, 0));
    wr(wd(16, 1, 0)); chk("R3 ID 16 not in mask", rd, wd(0, 1, 0));
    #600;
    measure(1'b0, per, hi);
    chk("R3 old source new ratio period", per, 12);

    wr(32'hE000_0002 | wd(9, 3, 0));
    chk("R2 unused bits read zero", rd, wd(9, 3, 0));

    wr(wd(0, 0, 0));
    #600;
    min_hi = 1.0e9;
    min_lo = 1.0e9;
    arm = 1'b1;
    wr(wd(9, 0, 0));
    #600;
    wr(wd(1, 0, 0));
    #600;
    wr(wd(9, 0, 0));
    #600;
    arm = 1'b0;
    chk("R7 shortest high pulse >= 3ns", (min_hi >= 3.0) ? 1 : 0, 1);
    chk("R7 shortest low pulse >= 3ns", (min_lo >= 3.0) ? 1 : 0, 1);
    measure(1'b0, per, hi);
    chk("R7 period after switch", per, 24);

    wr(wd(9, 0, 1));
    #600;
    chk("R6 power-down readback", rd, wd(9, 0, 1));
    measure(1'b0, per, hi);
    chk("R6 no edges while powered down", per, 0);
    chk("R6 output held low", co, 0);
    wr(wd(9, 0, 0));
    #600;
    measure(1'b0, per, hi);
    chk("R6 restart period", per, 24);

    wr(wd(12, 1, 1));
    #600;
    chk("R6 R7 combined write readback", rd, wd(12, 1, 1));
    measure(1'b0, per, hi);
    chk("R6 silent across switch", per, 0);
    measure(1'b1, per, hi);
    chk("R8 safe output runs through power-down write", per, 8);
    wr(wd(12, 1, 0));
    #600;
    measure(1'b0, per, hi);
    chk("R4 new source after restart", per, 60);
    chk("R5 high time after restart", hi, 30);

    chk("R8 safe word unchanged", rd_s, 32'h0100_0000);
    wr(wd(9, 15, 1));
    chk("R9 safe divide field reads zero", rd_s, 32'h0100_0000);
    #600;
    measure(1'b1, per, hi);
    chk("R9 undivided period", per, 8);
    chk("R9 undivided high time", hi, 4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule